// File: doc/BRIEF.md
# Serial Channel Receive/Transmit Buffer Pair with DMA Ready Signalling

This block holds the character buffers of one serial channel. On the receive side, the deserializer pushes each character with its three error flags (parity, framing, break). The CPU pops a character and its flags together with one read strobe. On the transmit side, the CPU pushes bytes and the serializer pops them. Both buffers read first-word-fall-through: the head entry sits on the read port before the strobe.

Two active-low ready outputs pace a DMA engine. In single-character operation, receive-ready asks for service as soon as any character is present. Transmit-ready offers space while the transmit buffer is empty. In block operation, receive-ready asserts once the fill reaches a selectable trigger level, or when the time-out input fires with data present. It then holds until the buffer is drained. Transmit-ready drops whenever any slot is free. When the buffers are disabled, each side shrinks to a single holding register.

The receive-ready logic is a two-state machine. RR_IDLE holds the output high. RR_IDLE goes to RR_SERVE when its start condition is met: any data in single operation, or trigger/time-out in block operation. RR_SERVE drives the output low and returns to RR_IDLE when the buffer is empty.

The transmit-ready logic is also a two-state machine. TR_OPEN drives the output low. TR_OPEN goes to TR_HELD when the buffer becomes non-empty (single operation) or full (block operation). TR_HELD drives the output high and returns to TR_OPEN when the buffer becomes empty (single operation) or is no longer full (block operation).

Both ready outputs are Moore outputs of these machines. Each one lags the buffer level by one clock.

Top module: `chan_buffer_pair`

## Requirements
- R1: Each buffer holds up to DEPTH (16) entries. A push into a full buffer is discarded and leaves the level unchanged.
- R2: Entries leave in arrival order. A receive entry returns the byte and its 3-bit error field exactly as they were written.
- R3: trig_sel picks the receive trigger: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters. rx_trig_hit is high exactly while rx_level is at or above the trigger. It therefore clears as soon as the level falls below the trigger.
- R4: In single-character operation (dma_mode=0), rx_ready_n goes low in the cycle after rx_level becomes nonzero, regardless of the trigger. It goes high in the cycle after the level returns to zero.
- R5: In block operation (fifo_en=1, dma_mode=1), rx_ready_n goes low one cycle after the level reaches the trigger. It also goes low one cycle after rx_timeout is seen high while the level is nonzero. A time-out with an empty buffer has no effect. Once low, rx_ready_n stays low until the cycle after the buffer is empty.
- R6: In single-character operation, tx_ready_n is low while the transmit buffer is empty and high while it holds data, each one cycle after the level changes.
- R7: In block operation, tx_ready_n is high only while the transmit buffer is full, one cycle after the level changes.
- R8: A pulse on rx_clr empties only the receive buffer, and a pulse on tx_clr empties only the transmit buffer. Each takes effect at the next clock edge.
- R9: A receive push that is discarded because the buffer is full raises rx_overrun for exactly the following cycle.
- R10: With fifo_en=0, each buffer holds one entry and the trigger is 1. dma_mode is ignored, and the ready outputs behave as in single-character operation.
- R11: After reset, both levels are 0, rx_ready_n is high, tx_ready_n is low, and rx_trig_hit and rx_overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 = full-depth buffers, 0 = single holding register per side |
| dma_mode | input | 1 | 1 = block ready signalling (only while fifo_en=1) |
| trig_sel | input | 2 | Receive trigger select |
| rx_clr | input | 1 | Empty the receive buffer |
| tx_clr | input | 1 | Empty the transmit buffer |
| rx_wr | input | 1 | Push strobe from the deserializer |
| rx_wr_data | input | 8 | Received byte |
| rx_wr_err | input | 3 | Error flags of the received byte |
| rx_rd | input | 1 | CPU read strobe |
| rx_rd_data | output | 8 | Head receive byte |
| rx_rd_err | output | 3 | Error flags of the head receive byte |
| rx_timeout | input | 1 | Receive time-out indication |
| rx_level | output | 5 | Receive fill level |
| rx_trig_hit | output | 1 | Receive level at or above trigger |
| rx_overrun | output | 1 | One-cycle pulse after a discarded receive push |
| rx_ready_n | output | 1 | Receive ready, active low |
| tx_wr | input | 1 | CPU push strobe |
| tx_wr_data | input | 8 | Byte to transmit |
| tx_rd | input | 1 | Pop strobe from the serializer |
| tx_rd_data | output | 8 | Head transmit byte |
| tx_level | output | 5 | Transmit fill level |
| tx_ready_n | output | 1 | Transmit ready, active low |

## Verification
The bench builds the block with its default DEPTH of 16, 8-bit data and 3 error bits. At this size every fill level from empty through overflow can be visited directly. The receive buffer is filled and drained completely for each of the four trigger selections. The transmit buffer is swept the same way in both signalling modes. This brings every state and transition of both ready machines within reach, including the receive drain hysteresis, time-outs with and without data, and the one-deep disabled configuration.

// File: rtl/chbuf_pkg.sv
package chbuf_pkg;

    typedef enum logic {
        RR_IDLE,
        RR_SERVE
    } rx_rdy_state_t;

    typedef enum logic {
        TR_OPEN,
        TR_HELD
    } tx_rdy_state_t;

    typedef enum logic [1:0] {
        TRIG_ONE,
        TRIG_QUARTER,
        TRIG_HALF,
        TRIG_NEAR_FULL
    } trig_sel_t;

    // Trigger level in characters for a selector value and buffer depth.
    function automatic int unsigned trig_chars(input logic [1:0] sel, input int unsigned depth);
        int unsigned r;
        unique case (trig_sel_t'(sel))
            TRIG_ONE:       r = 1;
            TRIG_QUARTER:   r = depth / 4;
            TRIG_HALF:      r = depth / 2;
            TRIG_NEAR_FULL: r = depth - 2;
            default:        r = 1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chbuf_store.sv
module chbuf_store #(
    parameter  int W     = 8,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shallow,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          rd_ok, wr_ok;

    always_comb begin
        empty = (cnt_q == '0);
        full  = shallow ? !empty : (cnt_q >= FULL_CNT);
        rd_ok = rd && !empty;
        wr_ok = wr && (!full || rd_ok);
        count = cnt_q;
        rdata = mem[rptr_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ok) wptr_q <= wptr_q + 1'b1;
            if (rd_ok) rptr_q <= rptr_q + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !clr) mem[wptr_q] <= wdata;
    end

    // R1: level never exceeds the depth
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R1: a push into a full buffer without a pop leaves the level alone
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd && !clr) |=> (count == $past(count)));

    // R8: clear empties the buffer at the next edge
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

endmodule

// File: rtl/chbuf_rx_ready.sv
module chbuf_rx_ready #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block_mode,
    input  logic          timeout,
    input  logic          empty,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] trig,
    output logic          ready_n,
    output logic          trig_hit
);
    import chbuf_pkg::*;

    rx_rdy_state_t state_q, state_d;
    logic          start;

    always_comb begin
        start   = block_mode ? ((count >= trig) || (timeout && !empty)) : !empty;
        state_d = state_q;
        unique case (state_q)
            RR_IDLE:  if (start) state_d = RR_SERVE;
            RR_SERVE: if (empty) state_d = RR_IDLE;
            default:  state_d = RR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready_n  = (state_q != RR_SERVE);
        trig_hit = (count >= trig);
    end

    // R4: ready only ever asserted with data present on the previous edge
    p_rx_rdy_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_n |-> ($past(count) != '0));

endmodule

// File: rtl/chbuf_tx_ready.sv
module chbuf_tx_ready #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block_mode,
    input  logic          full,
    input  logic          empty,
    input  logic [CW-1:0] count,
    output logic          ready_n
);
    import chbuf_pkg::*;

    tx_rdy_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TR_OPEN: if (block_mode ? full : !empty) state_d = TR_HELD;
            TR_HELD: if (block_mode ? !full : empty) state_d = TR_OPEN;
            default: state_d = TR_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TR_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        ready_n = (state_q == TR_HELD);
    end

    // R6: transmit never reports busy when it was empty the edge before
    p_tx_held_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_n |-> ($past(count) != '0));

endmodule

// File: rtl/chan_buffer_pair.sv
module chan_buffer_pair #(
    parameter  int DW    = 8,
    parameter  int EW    = 3,
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          dma_mode,
    input  logic [1:0]    trig_sel,
    input  logic          rx_clr,
    input  logic          tx_clr,
    input  logic          rx_wr,
    input  logic [DW-1:0] rx_wr_data,
    input  logic [EW-1:0] rx_wr_err,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rd_data,
    output logic [EW-1:0] rx_rd_err,
    input  logic          rx_timeout,
    output logic [CW-1:0] rx_level,
    output logic          rx_trig_hit,
    output logic          rx_overrun,
    output logic          rx_ready_n,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wr_data,
    input  logic          tx_rd,
    output logic [DW-1:0] tx_rd_data,
    output logic [CW-1:0] tx_level,
    output logic          tx_ready_n
);
    import chbuf_pkg::*;

    localparam int RW = DW + EW;

    logic          block_eff, shallow;
    logic [CW-1:0] trig_eff;
    logic [RW-1:0] rx_head;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic          ovr_d, ovr_q;

    always_comb begin
        shallow   = !fifo_en;
        block_eff = fifo_en && dma_mode;
        trig_eff  = fifo_en ? CW'(trig_chars(trig_sel, DEPTH)) : CW'(1);
        ovr_d     = rx_wr && rx_full && !(rx_rd && !rx_empty) && !rx_clr;
        rx_rd_data = rx_head[RW-1:EW];
        rx_rd_err  = rx_head[EW-1:0];
        rx_overrun = ovr_q;
    end

    chbuf_store #(.W(RW), .DEPTH(DEPTH)) u_rx_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .shallow (shallow),
        .wr      (rx_wr),
        .wdata   ({rx_wr_data, rx_wr_err}),
        .rd      (rx_rd),
        .rdata   (rx_head),
        .count   (rx_level),
        .full    (rx_full),
        .empty   (rx_empty)
    );

    chbuf_store #(.W(DW), .DEPTH(DEPTH)) u_tx_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_clr),
        .shallow (shallow),
        .wr      (tx_wr),
        .wdata   (tx_wr_data),
        .rd      (tx_rd),
        .rdata   (tx_rd_data),
        .count   (tx_level),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    chbuf_rx_ready #(.CW(CW)) u_rx_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_mode (block_eff),
        .timeout    (rx_timeout),
        .empty      (rx_empty),
        .count      (rx_level),
        .trig       (trig_eff),
        .ready_n    (rx_ready_n),
        .trig_hit   (rx_trig_hit)
    );

    chbuf_tx_ready #(.CW(CW)) u_tx_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_mode (block_eff),
        .full       (tx_full),
        .empty      (tx_empty),
        .count      (tx_level),
        .ready_n    (tx_ready_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    // R9: an overrun pulse follows a push that met a non-empty buffer
    p_overrun_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> ($past(rx_wr) && ($past(rx_level) != '0)));

endmodule

// File: tb/test_chan_buffer_pair.sv
module test_chan_buffer_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1, dma_mode = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rx_clr = 1'b0, tx_clr = 1'b0;
    logic       rx_wr = 1'b0, rx_rd = 1'b0, rx_timeout = 1'b0;
    logic [7:0] rx_wr_data = '0;
    logic [2:0] rx_wr_err = '0;
    logic [7:0] rx_rd_data;
    logic [2:0] rx_rd_err;
    logic [4:0] rx_level, tx_level;
    logic       rx_trig_hit, rx_overrun, rx_ready_n;
    logic       tx_wr = 1'b0, tx_rd = 1'b0;
    logic [7:0] tx_wr_data = '0;
    logic [7:0] tx_rd_data;
    logic       tx_ready_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    chan_buffer_pair i_chan_buffer_pair (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_sel(trig_sel), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .rx_wr(rx_wr), .rx_wr_data(rx_wr_data), .rx_wr_err(rx_wr_err),
        .rx_rd(rx_rd), .rx_rd_data(rx_rd_data), .rx_rd_err(rx_rd_err),
        .rx_timeout(rx_timeout), .rx_level(rx_level), .rx_trig_hit(rx_trig_hit),
        .rx_overrun(rx_overrun), .rx_ready_n(rx_ready_n),
        .tx_wr(tx_wr), .tx_wr_data(tx_wr_data), .tx_rd(tx_rd),
        .tx_rd_data(tx_rd_data), .tx_level(tx_level), .tx_ready_n(tx_ready_n)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic push_rx(input logic [7:0] d, input logic [2:0] e);
        rx_wr = 1'b1; rx_wr_data = d; rx_wr_err = e;
        cyc();
        rx_wr = 1'b0;
    endtask

    task automatic pop_rx();
        rx_rd = 1'b1;
        cyc();
        rx_rd = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_wr = 1'b1; tx_wr_data = d;
        cyc();
        tx_wr = 1'b0;
    endtask

    task automatic pop_tx();
        tx_rd = 1'b1;
        cyc();
        tx_rd = 1'b0;
    endtask

    task automatic clear_all();
        rx_clr = 1'b1; tx_clr = 1'b1;
        cyc();
        rx_clr = 1'b0; tx_clr = 1'b0;
        cyc();
        cyc();
    endtask

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 17 + s * 3 + 5) & 8'hff);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R11: reset state
        check("R11 rx_level", int'(rx_level), 0);
        check("R11 tx_level", int'(tx_level), 0);
        check("R11 rx_ready_n", int'(rx_ready_n), 1);
        check("R11 tx_ready_n", int'(tx_ready_n), 0);
        check("R11 rx_trig_hit", int'(rx_trig_hit), 0);
        check("R11 rx_overrun", int'(rx_overrun), 0);

        // R1 R2 R3 R5 R9: full receive sweep per trigger selection, block mode
        for (int s = 0; s < 4; s++) begin
            int trig;
            trig = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            fifo_en = 1'b1; dma_mode = 1'b1; trig_sel = 2'(s);
            clear_all();
            for (int n = 1; n <= 16; n++) begin
                push_rx(pat(n - 1, s), 3'((n - 1) % 8));
                check("R1 rx level fill", int'(rx_level), n);
                check("R3 trig_hit fill", int'(rx_trig_hit), int'(n >= trig));
                cyc();
                check("R5 rx_ready_n fill", int'(rx_ready_n), int'(!(n >= trig)));
            end
            push_rx(8'hAA, 3'd7);
            check("R1 rx full drop", int'(rx_level), 16);
            check("R9 overrun pulse", int'(rx_overrun), 1);
            cyc();
            check("R9 overrun one cycle", int'(rx_overrun), 0);
            for (int i = 0; i < 16; i++) begin
                int r;
                check("R2 rx data order", int'(rx_rd_data), int'(pat(i, s)));
                check("R2 rx err flags", int'(rx_rd_err), i % 8);
                pop_rx();
                r = 15 - i;
                check("R3 trig_hit drain", int'(rx_trig_hit), int'(r >= trig));
                cyc();
                check("R5 rx_ready_n hold until empty", int'(rx_ready_n), int'(r == 0));
            end
        end

        // R4: single-character receive ready ignores the trigger
        fifo_en = 1'b1; dma_mode = 1'b0; trig_sel = 2'd3;
        clear_all();
        push_rx(8'h11, 3'd1);
        cyc();
        check("R4 rx_ready_n one char", int'(rx_ready_n), 0);
        push_rx(8'h22, 3'd2);
        pop_rx();
        cyc();
        check("R4 rx_ready_n still data", int'(rx_ready_n), 0);
        pop_rx();
        cyc();
        check("R4 rx_ready_n empty", int'(rx_ready_n), 1);

        // R5: time-out in block mode
        dma_mode = 1'b1;
        clear_all();
        push_rx(8'h31, 3'd0);
        push_rx(8'h32, 3'd0);
        cyc();
        check("R5 below trigger", int'(rx_ready_n), 1);
        rx_timeout = 1'b1;
        cyc();
        rx_timeout = 1'b0;
        check("R5 timeout asserts", int'(rx_ready_n), 0);
        cyc();
        check("R5 timeout holds", int'(rx_ready_n), 0);
        pop_rx();
        pop_rx();
        cyc();
        check("R5 released when empty", int'(rx_ready_n), 1);
        rx_timeout = 1'b1;
        cyc();
        rx_timeout = 1'b0;
        cyc();
        check("R5 timeout empty ignored", int'(rx_ready_n), 1);

        // R1 R2 R6 R7: transmit sweep in both modes
        for (int m = 0; m < 2; m++) begin
            fifo_en = 1'b1; dma_mode = m[0]; trig_sel = 2'd0;
            clear_all();
            for (int n = 1; n <= 16; n++) begin
                push_tx(pat(n, 7));
                check("R1 tx level fill", int'(tx_level), n);
                cyc();
                if (m == 1) check("R7 tx_ready_n fill", int'(tx_ready_n), int'(n == 16));
                else        check("R6 tx_ready_n fill", int'(tx_ready_n), 1);
            end
            push_tx(8'h5A);
            check("R1 tx full drop", int'(tx_level), 16);
            for (int i = 0; i < 16; i++) begin
                int r;
                check("R2 tx data order", int'(tx_rd_data), int'(pat(i + 1, 7)));
                pop_tx();
                r = 15 - i;
                cyc();
                if (m == 1) check("R7 tx_ready_n drain", int'(tx_ready_n), 0);
                else        check("R6 tx_ready_n drain", int'(tx_ready_n), int'(r != 0));
            end
        end

        // R8: independent clears
        fifo_en = 1'b1; dma_mode = 1'b0;
        clear_all();
        for (int i = 0; i < 3; i++) push_rx(8'(8'h40 + i), 3'd0);
        for (int i = 0; i < 5; i++) push_tx(8'(8'h60 + i));
        rx_clr = 1'b1;
        cyc();
        rx_clr = 1'b0;
        check("R8 rx cleared", int'(rx_level), 0);
        check("R8 tx untouched level", int'(tx_level), 5);
        check("R8 tx untouched head", int'(tx_rd_data), 8'h60);
        push_rx(8'h71, 3'd3);
        push_rx(8'h72, 3'd4);
        tx_clr = 1'b1;
        cyc();
        tx_clr = 1'b0;
        check("R8 tx cleared", int'(tx_level), 0);
        check("R8 rx untouched level", int'(rx_level), 2);
        check("R8 rx untouched head", int'(rx_rd_data), 8'h71);

        // R10: disabled buffers act as single holding registers
        fifo_en = 1'b0; dma_mode = 1'b1; trig_sel = 2'd3;
        clear_all();
        push_rx(8'h81, 3'd5);
        check("R10 rx one entry", int'(rx_level), 1);
        check("R10 trigger is one", int'(rx_trig_hit), 1);
        cyc();
        check("R10 rx_ready_n", int'(rx_ready_n), 0);
        push_rx(8'h82, 3'd6);
        check("R10 rx second dropped", int'(rx_level), 1);
        check("R10 overrun", int'(rx_overrun), 1);
        check("R10 rx keeps first", int'(rx_rd_data), 8'h81);
        check("R10 rx keeps first err", int'(rx_rd_err), 5);
        pop_rx();
        cyc();
        check("R10 rx_ready_n empty", int'(rx_ready_n), 1);
        push_tx(8'h91);
        cyc();
        check("R10 tx_ready_n held", int'(tx_ready_n), 1);
        push_tx(8'h92);
        check("R10 tx second dropped", int'(tx_level), 1);
        check("R10 tx keeps first", int'(tx_rd_data), 8'h91);
        pop_tx();
        cyc();
        check("R10 tx_ready_n open", int'(tx_ready_n), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule